// File: doc/BRIEF.md
# Bidirectional GPIO Register Bank

This block gives software control over thirty-two general-purpose pins, grouped as four byte-wide ports. A simple byte bus with an address, a write strobe, write data and registered read data reaches two registers per port. The output latch sets the level each pin drives, and the direction register selects whether the pin drives at all. The block sends a value and an output-enable to each pad. It takes each pad's level back through a two-flop synchroniser.

Reads of a latch register depend on each bit's direction. A bit set as an output returns what software wrote. A bit set as an input returns the synchronised pin level. A bit marked open-drain by its configuration input also returns the pin level, and such a pin only pulls low. The third port has just three pins. Its five upper bits ignore writes and always read as one.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the latch and direction registers of ports 0, 1 and 3 read 0x00, both port-2 registers read 0xF8, and every pin_oe bit is 0.
- R2: Byte address 2*p reaches the latch register of port p, and address 2*p+1 reaches its direction register (p = 0..3). A write changes only the addressed register.
- R3: For a pin whose pin_od bit is 0, pin_oe follows its direction bit (1 = output, 0 = input). pin_out always carries the latch bit. Port p occupies bits 8p+7..8p of every pin vector.
- R4: A latch write always updates the latch, and so pin_out, even for bits whose direction is input.
- R5: A latch-register read returns the latch for bits that have direction 1 and pin_od 0. For every other bit it returns the synchronised pin level.
- R6: For a pin with pin_od set, pin_oe is 1 only while the direction bit is 1 and the latch bit is 0. A read of that bit returns the pin level.
- R7: Port 2 implements bits 2..0 only. Writes to bits 7..3 are ignored, those bits read as 1 in both registers, and pins 23..19 keep pin_out and pin_oe at 0.
- R8: Addresses 8 and above read as 0x00, and writes to them change no register.
- R9: A change on pin_in first shows in bus_rdata after the third rising edge, when the address is held on an input bit. The value sampled after the first two edges is still the old one.
- R10: bus_rdata is registered. It shows the register selected by bus_addr at the previous rising edge, so back-to-back reads of different addresses each return their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 32 | Pad input levels, 8 per port |
| pin_od | input | 32 | Per-pin open-drain configuration |
| pin_out | output | 32 | Per-pin drive value |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The bench writes to latch bits whose direction is input. A design that gates the latch on direction would then lose the value once the pin turns to output. It reads latches that hold a mix of input and output bits against pin patterns that differ from the latch, so a mux that picks the wrong source for some bits gives a wrong byte. Open-drain pins are checked for enable only while driving low and for readback of the pad level, not the latch. The bench also covers:
- writes to the narrow port's upper bits and to addresses beyond the map, which must leave no trace;
- the exact edge on which a pin change first appears, which catches a missing or extra synchroniser stage.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NUM_PORTS  = 4;
    localparam int PORT_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NARROW_IDX = 2;
    localparam int NARROW_W   = 3;
    localparam int BANK_W     = NUM_PORTS * PORT_W;
    localparam int REG_SPAN   = 2 * NUM_PORTS;
    localparam int PIDX_W     = $clog2(NUM_PORTS);

    typedef logic [PORT_W-1:0] byte_t;

    typedef enum logic {
        SEL_LATCH = 1'b0,
        SEL_DIR   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [PIDX_W-1:0] port;
        reg_sel_e          sel;
    } decode_t;

    typedef struct packed {
        byte_t latch_view;
        byte_t dir_view;
    } port_view_t;

    function automatic int impl_width(input int idx);
        return (idx == NARROW_IDX) ? NARROW_W : PORT_W;
    endfunction

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.hit  = (a < ADDR_W'(REG_SPAN));
        d.port = a[PIDX_W:1];
        d.sel  = reg_sel_e'(a[0]);
        return d;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int IMPL_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we_latch,
    input  logic       we_dir,
    input  byte_t      wdata,
    input  byte_t      pin_sync,
    input  byte_t      od_cfg,
    output byte_t      pin_out,
    output byte_t      pin_oe,
    output port_view_t view
);
    localparam byte_t IMPL_MASK = byte_t'((1 << IMPL_W) - 1);

    byte_t latch_q;
    byte_t dir_q;
    byte_t own_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (we_latch) latch_q <= wdata & IMPL_MASK;
            if (we_dir)   dir_q   <= wdata & IMPL_MASK;
        end
    end

    // Push-pull outputs read their own latch; inputs and open-drain read the pad.
    assign own_bits = dir_q & ~od_cfg;

    assign pin_out = latch_q;
    assign pin_oe  = dir_q & ~(od_cfg & latch_q) & IMPL_MASK;

    assign view.latch_view = (((own_bits & latch_q) | (~own_bits & pin_sync)) & IMPL_MASK)
                             | ~IMPL_MASK;
    assign view.dir_view   = dir_q | ~IMPL_MASK;
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  decode_t    dec,
    input  port_view_t views [NUM_PORTS],
    output byte_t      rdata
);
    byte_t rdata_d;

    always_comb begin
        rdata_d = '0;
        if (dec.hit) begin
            rdata_d = (dec.sel == SEL_DIR) ? views[dec.port].dir_view
                                           : views[dec.port].latch_view;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rdata_d;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [BANK_W-1:0] pin_in,
    input  logic [BANK_W-1:0] pin_od,
    output logic [BANK_W-1:0] pin_out,
    output logic [BANK_W-1:0] pin_oe
);
    decode_t           dec;
    logic [BANK_W-1:0] pin_sync;
    port_view_t        views [NUM_PORTS];

    assign dec = decode_addr(bus_addr);

    gpio_sync #(.W(BANK_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic we_latch;
        logic we_dir;

        assign we_latch = bus_we && dec.hit && (dec.port == PIDX_W'(p)) && (dec.sel == SEL_LATCH);
        assign we_dir   = bus_we && dec.hit && (dec.port == PIDX_W'(p)) && (dec.sel == SEL_DIR);

        gpio_port #(.IMPL_W(impl_width(p))) u_port (
            .clk      (clk),
            .rst      (rst),
            .we_latch (we_latch),
            .we_dir   (we_dir),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync[p*PORT_W +: PORT_W]),
            .od_cfg   (pin_od[p*PORT_W +: PORT_W]),
            .pin_out  (pin_out[p*PORT_W +: PORT_W]),
            .pin_oe   (pin_oe[p*PORT_W +: PORT_W]),
            .view     (views[p])
        );
    end

    gpio_readmux u_mux (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .views (views),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [BANK_W-1:0] pin_od,
    input logic [BANK_W-1:0] pin_out,
    input logic [BANK_W-1:0] pin_oe
);
    // R3: direction write on port 0 with no open-drain pins sets the enables
    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'd1 && pin_od[7:0] == 8'h00) |=> pin_oe[7:0] == $past(bus_wdata));

    // R4: latch write on port 0 reaches pin_out regardless of direction
    a_r4_latch_to_pin: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'd0) |=> pin_out[7:0] == $past(bus_wdata));

    // R6: an enabled open-drain pin only ever drives low
    a_r6_od_low_only: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_od & pin_out) == '0);

    // R7: unimplemented port-2 pins never drive
    a_r7_narrow_pins: assert property (@(posedge clk) disable iff (rst)
        pin_oe[23:19] == 5'b0 && pin_out[23:19] == 5'b0);

    // R7: port-2 reads show ones in the unimplemented bits
    a_r7_narrow_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'd4 || bus_addr == 8'd5) |=> bus_rdata[7:3] == 5'b11111);

    // R8: out-of-range reads are zero
    a_r8_oob_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= 8'd8) |=> bus_rdata == 8'h00);

    // R8: out-of-range writes leave every latch untouched
    a_r8_oob_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr >= 8'd8) |=> $stable(pin_out));
endmodule

bind gpio_bank gpio_bank_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_od    (pin_od),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_od = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_od(pin_od), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {addr, wdata, expected readback}; pins fixed at D=A5 C=5A B=C3 A=3C
    localparam logic [23:0] VECS [0:12] = '{
        24'h01_FF_FF, 24'h00_96_96, 24'h01_0F_0F, 24'h00_00_30,
        24'h03_F0_F0, 24'h02_5A_53, 24'h05_FF_FF, 24'h05_02_FA,
        24'h04_07_FA, 24'h07_3C_3C, 24'h06_C3_81, 24'h08_FF_00,
        24'hFF_12_00
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int a = 0; a < 8; a++) begin
            rd(8'(a), r);
            check("R1 reset read", {24'h0, r}, (a == 4 || a == 5) ? 32'hF8 : 32'h00);
        end
        check("R1 reset oe", pin_oe, 32'h0);

        // Table: R2 decode, R5 mixed readback, R7 narrow port, R8 out of range
        pin_in = 32'hA5_5A_C3_3C;
        for (int i = 0; i < 13; i++) begin
            wr(VECS[i][23:16], VECS[i][15:8]);
            rd(VECS[i][23:16], r);
            check("R2/R5/R7/R8 table", {24'h0, r}, {24'h0, VECS[i][7:0]});
        end
        // R3 pin drive and enables; R8 writes above the map left no trace
        check("R3/R8 pin_out", pin_out, 32'hC3_07_5A_00);
        check("R3 pin_oe", pin_oe, 32'h3C_02_F0_0F);

        // R4 latch write lands on input bits
        wr(8'h00, 8'hF0);
        check("R4 pin_out on input bits", {24'h0, pin_out[7:0]}, 32'hF0);
        wr(8'h01, 8'hFF);
        rd(8'h00, r);
        check("R4 latched input bits readback", {24'h0, r}, 32'hF0);

        // R6 open drain: enable only where latch is 0, read pad level
        pin_od[7:0] = 8'hFF;
        @(negedge clk);
        check("R6 od enable", {24'h0, pin_oe[7:0]}, 32'h0F);
        rd(8'h00, r);
        check("R6 od readback", {24'h0, r}, 32'h3C);
        pin_od[7:0] = 8'h00;

        // R9 synchroniser timing on input bits
        wr(8'h01, 8'h00);
        @(negedge clk);
        bus_addr = 8'h00;
        repeat (4) @(negedge clk);
        pin_in[7:0] = 8'h81;
        @(negedge clk);
        check("R9 after edge 1", {24'h0, bus_rdata}, 32'h3C);
        @(negedge clk);
        check("R9 after edge 2", {24'h0, bus_rdata}, 32'h3C);
        @(negedge clk);
        check("R9 after edge 3", {24'h0, bus_rdata}, 32'h81);

        // R10 back-to-back reads, one-cycle latency
        @(negedge clk);
        bus_addr = 8'h03;
        @(negedge clk);
        check("R10 first read", {24'h0, bus_rdata}, 32'hF0);
        bus_addr = 8'h07;
        @(negedge clk);
        check("R10 second read", {24'h0, bus_rdata}, 32'h3C);

        // R7 upper bits of port 2 ignore writes
        wr(8'h05, 8'hF8);
        rd(8'h05, r);
        check("R7 narrow dir upper ignored", {24'h0, r}, 32'hF8);
        check("R7 narrow pins idle", {27'h0, pin_oe[23:19]}, 32'h0);

        finish_run();
    end
endmodule